// File: doc/BRIEF.md
# DMA Transfer Checksum Sniffer

This block watches the data words moved by a DMA engine and folds those from one chosen channel into a single 32-bit running result. The result can be a CRC-32, a CRC-16 (CCITT polynomial), either CRC fed with bit-reversed words, a running parity bit, or a modular sum. One accumulator register holds the result for every mode. A seed write port preloads that register before a transfer starts.

A beat counts only when all of the following hold:
- the unit is switched on,
- the beat's channel index equals the selected channel,
- that channel's per-beat sniff flag is set,
- the beat is valid.

An optional local byte reversal is applied to each counted word before it enters the calculation. If the channel already swapped its bytes upstream, turning on this reversal restores the original byte order. A control value of all zeros therefore switches the unit off and leaves the accumulator frozen. Each 32-bit word is absorbed in one clock cycle.

Top module: `dma_sniff_csum`

## Requirements
- R1: After reset `acc_out` is 0x00000000.
- R2: When `seed_we` is high at a clock edge, `acc_out` equals `seed_data` after that edge, whatever the mode.
- R3: If a seed write and a counted beat fall on the same edge, the seed wins and the beat is discarded.
- R4: A beat changes `acc_out` on the next edge only if `cfg_en` is 1, `beat_chan` equals `cfg_chan_sel`, `beat_sniff_en` is 1 and `beat_valid` is 1. If any of these is missing, `acc_out` holds its value.
- R5: Mode 4'h0 computes a CRC-32 with polynomial 0x04C11DB7 over the 32-bit accumulator. The word's bits are taken bit 31 first, with no reflection and no final inversion.
- R6: Mode 4'h1 reverses the word's bit order (bit i moves to bit 31-i) and then applies the R5 update.
- R7: Mode 4'h2 computes a CRC-16 with polynomial 0x1021 over `acc_out[15:0]`, taking the word's bits from bit 31 first. After the update `acc_out[31:16]` is zero.
- R8: Mode 4'h3 reverses the word's bit order as in R6 and then applies the R7 update.
- R9: Mode 4'hE sets `acc_out` to {31'b0, old bit 0 XOR parity of the word}, so bit 0 is 1 when the total count of one bits seen is odd.
- R10: Mode 4'hF adds the word to `acc_out` modulo 2^32.
- R11: With `cfg_swap` set, the word's byte order is reversed (byte 0 becomes byte 3) before any mode-specific step. Feeding an already byte-swapped word with `cfg_swap` set gives the same result as the original word with `cfg_swap` clear.
- R12: A counted beat in any mode other than 0, 1, 2, 3, E or F leaves `acc_out` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Unit enable |
| cfg_chan_sel | input | CH_W | Channel to observe |
| cfg_mode | input | 4 | Calculation mode |
| cfg_swap | input | 1 | Local byte reversal enable |
| beat_chan | input | CH_W | Channel index of the current beat |
| beat_sniff_en | input | 1 | Sniff flag of that channel |
| beat_valid | input | 1 | Data beat strobe |
| beat_data | input | 32 | Data word of the beat |
| seed_we | input | 1 | Accumulator load strobe |
| seed_data | input | 32 | Value to load |
| acc_out | output | 32 | Accumulator |

## Verification
A seed load and a counted beat can land on the same clock edge, because software may reseed while the selected channel is still moving data. The bench provokes this in summation mode by raising `seed_we` in the same cycle as a qualifying beat whose word would visibly change the sum. The accumulator must then hold exactly the seed, with no trace of the word. A checker property judges every such collision the same way during all other scenarios too.

// File: rtl/dma_sniff_pkg.sv
package dma_sniff_pkg;
  localparam int WORD_W = 32;
  localparam int NBYTES = WORD_W / 8;
  localparam logic [31:0] POLY32 = 32'h04C1_1DB7;
  localparam logic [15:0] POLY16 = 16'h1021;

  typedef enum logic [3:0] {
    MD_CRC32     = 4'h0,
    MD_CRC32_REV = 4'h1,
    MD_CRC16     = 4'h2,
    MD_CRC16_REV = 4'h3,
    MD_PARITY    = 4'hE,
    MD_SUM       = 4'hF
  } sniff_mode_e;

  function automatic logic [31:0] bit_rev32(input logic [31:0] d);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) r[i] = d[31-i];
    return r;
  endfunction

  function automatic logic [31:0] crc32_step(input logic [31:0] c, input logic [31:0] d);
    logic [31:0] s;
    logic fb;
    s = c;
    for (int i = 31; i >= 0; i--) begin
      fb = s[31] ^ d[i];
      s  = {s[30:0], 1'b0} ^ (fb ? POLY32 : 32'h0);
    end
    return s;
  endfunction

  function automatic logic [15:0] crc16_step(input logic [15:0] c, input logic [31:0] d);
    logic [15:0] s;
    logic fb;
    s = c;
    for (int i = 31; i >= 0; i--) begin
      fb = s[15] ^ d[i];
      s  = {s[14:0], 1'b0} ^ (fb ? POLY16 : 16'h0);
    end
    return s;
  endfunction
endpackage

// File: rtl/sniff_qualify.sv
module sniff_qualify #(
  parameter int CH_W = 4
) (
  input  logic            en,
  input  logic [CH_W-1:0] chan_sel,
  input  logic [CH_W-1:0] chan,
  input  logic            sniff_flag,
  input  logic            valid,
  output logic            hit
);
  always_comb hit = en & valid & sniff_flag & (chan == chan_sel);
endmodule

// File: rtl/sniff_prep.sv
module sniff_prep
  import dma_sniff_pkg::*;
(
  input  logic              swap,
  input  logic [WORD_W-1:0] din,
  output logic [WORD_W-1:0] dout
);
  for (genvar g = 0; g < NBYTES; g++) begin : g_byte
    assign dout[8*g +: 8] = swap ? din[8*(NBYTES-1-g) +: 8] : din[8*g +: 8];
  end
endmodule

// File: rtl/sniff_engine.sv
module sniff_engine
  import dma_sniff_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        mode,
  input  logic              hit,
  input  logic [WORD_W-1:0] word,
  input  logic              seed_we,
  input  logic [WORD_W-1:0] seed_data,
  output logic [WORD_W-1:0] acc
);
  logic [WORD_W-1:0] acc_nxt;
  logic [WORD_W-1:0] upd;
  logic [WORD_W-1:0] word_rev;

  always_comb word_rev = bit_rev32(word);

  always_comb begin
    case (mode)
      MD_CRC32:     upd = crc32_step(acc, word);
      MD_CRC32_REV: upd = crc32_step(acc, word_rev);
      MD_CRC16:     upd = {16'h0, crc16_step(acc[15:0], word)};
      MD_CRC16_REV: upd = {16'h0, crc16_step(acc[15:0], word_rev)};
      MD_PARITY:    upd = {31'h0, acc[0] ^ (^word)};
      MD_SUM:       upd = acc + word;
      default:      upd = acc;
    endcase
  end

  always_comb begin
    if (seed_we)  acc_nxt = seed_data;
    else if (hit) acc_nxt = upd;
    else          acc_nxt = acc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc <= '0;
    else        acc <= acc_nxt;
  end
endmodule

// File: rtl/dma_sniff_csum.sv
module dma_sniff_csum #(
  parameter int NUM_CH = 12,
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_en,
  input  logic [CH_W-1:0] cfg_chan_sel,
  input  logic [3:0]      cfg_mode,
  input  logic            cfg_swap,
  input  logic [CH_W-1:0] beat_chan,
  input  logic            beat_sniff_en,
  input  logic            beat_valid,
  input  logic [31:0]     beat_data,
  input  logic            seed_we,
  input  logic [31:0]     seed_data,
  output logic [31:0]     acc_out
);
  logic        beat_hit;
  logic [31:0] prep_word;

  sniff_qualify #(.CH_W(CH_W)) u_qual (
    .en(cfg_en), .chan_sel(cfg_chan_sel), .chan(beat_chan),
    .sniff_flag(beat_sniff_en), .valid(beat_valid), .hit(beat_hit)
  );

  sniff_prep u_prep (.swap(cfg_swap), .din(beat_data), .dout(prep_word));

  sniff_engine u_eng (
    .clk(clk), .rst_n(rst_n), .mode(cfg_mode), .hit(beat_hit),
    .word(prep_word), .seed_we(seed_we), .seed_data(seed_data), .acc(acc_out)
  );
endmodule

// File: rtl/dma_sniff_csum_chk.sv
module dma_sniff_csum_chk #(
  parameter int CH_W = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cfg_en,
  input logic [CH_W-1:0] cfg_chan_sel,
  input logic [CH_W-1:0] beat_chan,
  input logic            beat_sniff_en,
  input logic            beat_valid,
  input logic [3:0]      cfg_mode,
  input logic            hit,
  input logic [31:0]     prep_word,
  input logic            seed_we,
  input logic [31:0]     seed_data,
  input logic [31:0]     acc_out
);
  logic gate_open;
  always_comb gate_open = cfg_en & beat_valid & beat_sniff_en & (beat_chan == cfg_chan_sel);

  // R2 and R3: a seed load always wins
  a_r2_seed_load: assert property (@(posedge clk) disable iff (!rst_n)
    seed_we |=> acc_out == $past(seed_data));

  // R4: a closed gate holds the accumulator
  a_r4_gate_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!gate_open && !seed_we) |=> $stable(acc_out));

  // R4: the qualifier agrees with the gate conditions
  a_r4_hit_match: assert property (@(posedge clk) disable iff (!rst_n)
    hit == gate_open);

  // R7: CRC-16 leaves the upper half clear
  a_r7_crc16_upper: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !seed_we && (cfg_mode == 4'h2 || cfg_mode == 4'h3)) |=> acc_out[31:16] == 16'h0);

  // R9: parity keeps only bit 0
  a_r9_parity_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !seed_we && cfg_mode == 4'hE) |=> acc_out[31:1] == 31'h0);

  // R10: summation adds the prepared word
  a_r10_sum_add: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !seed_we && cfg_mode == 4'hF) |=> acc_out == $past(acc_out) + $past(prep_word));

  // R12: unused modes hold
  a_r12_unused_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !seed_we && cfg_mode inside {[4'h4:4'hD]}) |=> $stable(acc_out));
endmodule

bind dma_sniff_csum dma_sniff_csum_chk #(.CH_W(CH_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_chan_sel(cfg_chan_sel),
  .beat_chan(beat_chan), .beat_sniff_en(beat_sniff_en), .beat_valid(beat_valid),
  .cfg_mode(cfg_mode), .hit(beat_hit), .prep_word(prep_word),
  .seed_we(seed_we), .seed_data(seed_data), .acc_out(acc_out)
);

// File: tb/dma_sniff_csum_tb.sv
module dma_sniff_csum_tb;
  localparam int NUM_CH = 12;
  localparam int CH_W = $clog2(NUM_CH);

  logic clk = 0, rst_n = 0;
  logic cfg_en = 0, cfg_swap = 0, beat_sniff_en = 0, beat_valid = 0, seed_we = 0;
  logic [CH_W-1:0] cfg_chan_sel = '0, beat_chan = '0;
  logic [3:0] cfg_mode = 4'h0;
  logic [31:0] beat_data = '0, seed_data = '0;
  logic [31:0] acc_out;
  int total = 0, bad = 0, cyc = 0;

  always #2.5 clk = ~clk;

  dma_sniff_csum #(.NUM_CH(NUM_CH)) u_dut (.*);

  // reference models written in shift-and-test form
  function automatic logic [31:0] m_crc32(logic [31:0] c, logic [31:0] d);
    for (int k = 0; k < 32; k++) begin
      if (c[31] != d[31]) c = (c << 1) ^ 32'h04C11DB7; else c = c << 1;
      d = d << 1;
    end
    return c;
  endfunction
  function automatic logic [31:0] m_crc16(logic [31:0] c, logic [31:0] d);
    logic [15:0] s = c[15:0];
    for (int k = 0; k < 32; k++) begin
      if (s[15] != d[31]) s = (s << 1) ^ 16'h1021; else s = s << 1;
      d = d << 1;
    end
    return {16'h0, s};
  endfunction
  function automatic logic [31:0] m_rev(logic [31:0] d);
    logic [31:0] r = '0;
    for (int k = 0; k < 32; k++) r = (r << 1) | ((d >> k) & 1);
    return r;
  endfunction
  function automatic logic [31:0] m_bswap(logic [31:0] d);
    return {d[7:0], d[15:8], d[23:16], d[31:24]};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%08h exp=%08h", req, act, exp);
    end
  endtask

  task automatic seed(logic [31:0] v);
    @(negedge clk); seed_we = 1; seed_data = v;
    @(negedge clk); seed_we = 0;
  endtask

  // one beat, result sampled on the following negedge
  task automatic beat(logic [31:0] d, logic [CH_W-1:0] ch = 3, logic sf = 1);
    @(negedge clk); beat_valid = 1; beat_data = d; beat_chan = ch; beat_sniff_en = sf;
    @(negedge clk); beat_valid = 0;
  endtask

  task automatic t_reset();
    chk("R1 reset value", acc_out, 32'h0);
  endtask

  task automatic t_seed();
    seed(32'hDEADBEEF);
    chk("R2 seed load", acc_out, 32'hDEADBEEF);
  endtask

  task automatic t_crc32();
    logic [31:0] e;
    cfg_mode = 4'h0; seed(32'hFFFFFFFF); e = 32'hFFFFFFFF;
    beat(32'h12345678); e = m_crc32(e, 32'h12345678);
    chk("R5 crc32 beat1", acc_out, e);
    beat(32'h0000_0001); e = m_crc32(e, 32'h1);
    chk("R5 crc32 beat2", acc_out, e);
  endtask

  task automatic t_crc32_rev();
    logic [31:0] e;
    cfg_mode = 4'h1; seed(32'h0); e = 32'h1;
    seed(32'h1);
    beat(32'h80000003); e = m_crc32(e, m_rev(32'h80000003));
    chk("R6 crc32 bitrev", acc_out, e);
  endtask

  task automatic t_crc16();
    logic [31:0] e;
    cfg_mode = 4'h2; seed(32'hABCDFFFF); e = 32'hABCDFFFF;
    beat(32'hCAFEF00D); e = m_crc16(e, 32'hCAFEF00D);
    chk("R7 crc16", acc_out, e);
  endtask

  task automatic t_crc16_rev();
    logic [31:0] e;
    cfg_mode = 4'h3; seed(32'h0000_1D0F); e = 32'h1D0F;
    beat(32'h0F0F_1234); e = m_crc16(e, m_rev(32'h0F0F1234));
    chk("R8 crc16 bitrev", acc_out, e);
  endtask

  task automatic t_parity();
    cfg_mode = 4'hE; seed(32'h0);
    beat(32'h0000_0007);
    chk("R9 parity odd", acc_out, 32'h1);
    beat(32'h0000_0101);
    chk("R9 parity stays odd", acc_out, 32'h1);
    beat(32'h8000_0000);
    chk("R9 parity even", acc_out, 32'h0);
  endtask

  task automatic t_sum();
    cfg_mode = 4'hF; seed(32'hFFFFFFF0);
    beat(32'h0000_0005);
    chk("R10 sum", acc_out, 32'hFFFFFFF5);
    beat(32'h0000_0010);
    chk("R10 sum wrap", acc_out, 32'h00000005);
  endtask

  task automatic t_swap();
    cfg_mode = 4'hF; cfg_swap = 1; seed(32'h0);
    beat(32'h11223344);
    chk("R11 byte swap", acc_out, m_bswap(32'h11223344));
    seed(32'h0);
    beat(32'h44332211);
    chk("R11 swaps cancel", acc_out, 32'h11223344);
    cfg_swap = 0;
  endtask

  task automatic t_gate();
    cfg_mode = 4'hF; seed(32'h100);
    cfg_en = 0; beat(32'h1);
    chk("R4 disabled", acc_out, 32'h100);
    cfg_en = 1; beat(32'h1, 4);
    chk("R4 other channel", acc_out, 32'h100);
    beat(32'h1, 3, 0);
    chk("R4 sniff flag low", acc_out, 32'h100);
    @(negedge clk); beat_data = 32'h7; @(negedge clk);
    chk("R4 no valid", acc_out, 32'h100);
  endtask

  task automatic t_unused();
    cfg_mode = 4'h7; seed(32'h5A5A5A5A);
    beat(32'hFFFF0000);
    chk("R12 unused mode", acc_out, 32'h5A5A5A5A);
  endtask

  task automatic t_collide();
    cfg_mode = 4'hF; seed(32'h10);
    @(negedge clk); seed_we = 1; seed_data = 32'h2000;
    beat_valid = 1; beat_chan = 3; beat_sniff_en = 1; beat_data = 32'h55;
    @(negedge clk); seed_we = 0; beat_valid = 0;
    chk("R3 seed beats data", acc_out, 32'h2000);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      total++; bad++;
      $display("FAIL watchdog act=%0d exp=done", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    cfg_en = 1; cfg_chan_sel = 3;
    t_seed();
    t_crc32();
    t_crc32_rev();
    t_crc16();
    t_crc16_rev();
    t_parity();
    t_sum();
    t_swap();
    t_gate();
    t_unused();
    t_collide();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule